// File: doc/BRIEF.md
# Arbitrated Crossbar Memory Switch

This block joins a set of processor ports to a set of memory modules through a grid of crosspoints. Every processor presents an address, write data, a write-enable and a request on the same clock. The top address bits name a memory module. The remaining bits become the word address inside that module. Each crosspoint on a module's column checks whether its row is aiming at that column. It also holds its share of the arbitration, so one module is never handed to two processors in one cycle.

Arbitration is spread over the crosspoints and is not done by a central arbiter. A "taken" signal runs down each column from row 0 towards the last row. A crosspoint grants only when its processor is requesting that column and no row above it has already claimed the column. The lowest-indexed row therefore always wins. The acknowledge is combinational, so it arrives in the request cycle, before the memory acts on the edge. A processor that is not acknowledged keeps its request asserted and competes again on the next cycle. Read data from a registered memory comes back one cycle after the acknowledge, and only to the processor that owned the column.

Top module: `xbarSwitch`

## Requirements
- R1: The module index is address bits [ADDR_W-1 : ADDR_W-SEL_W], with SEL_W = log2(NUM_MEM). Bits [WORD_W-1:0] appear unchanged on the winning column's `memAddr` slice, and the slice is zero when the column is idle.
- R2: `memSel[j]` is high in a cycle exactly when some requesting processor targets module j. `memWe[j]` and the `memWdata` slice of column j then carry the winner's write-enable and write data.
- R3: `cpuAck[i]` settles within the same cycle as the request, with no register on the path, and is never high while `cpuReq[i]` is low.
- R4: When several processors target the same module in one cycle, exactly one is acknowledged: the one with the lowest index.
- R5: Requests to different modules in the same cycle are all acknowledged together, without affecting each other.
- R6: A losing processor that keeps its request asserted is acknowledged in the first later cycle in which no lower-indexed processor targets that module.
- R7: In the cycle after an acknowledged read, the processor's `cpuRdata` slice equals that module's registered read output. The slice of every other processor is zero.
- R8: An acknowledged write stores its data into the module, and the processor's `cpuRdata` slice is zero in the following cycle.
- R9: While `rstN` is low, the read-return state is cleared. In the cycle after a clock edge taken in reset, every `cpuRdata` slice is zero, even if a read was acknowledged in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all processors and memories |
| rstN | input | 1 | Active-low asynchronous reset of the read-return state |
| cpuReq | input | NUM_CPU | Per-processor request |
| cpuWe | input | NUM_CPU | Per-processor write-enable (1 = write) |
| cpuAddr | input | NUM_CPU*ADDR_W | Processor addresses, processor i at slice i |
| cpuWdata | input | NUM_CPU*DATA_W | Processor write data |
| cpuAck | output | NUM_CPU | Per-processor acknowledge, combinational |
| cpuRdata | output | NUM_CPU*DATA_W | Read data returned one cycle after the acknowledge |
| memSel | output | NUM_MEM | Per-module access strobe |
| memWe | output | NUM_MEM | Per-module write strobe |
| memAddr | output | NUM_MEM*WORD_W | Per-module word address |
| memWdata | output | NUM_MEM*DATA_W | Per-module write data |
| memRdata | input | NUM_MEM*DATA_W | Per-module registered read data |

## Verification
The assertions count one strobed module per acknowledged processor. That count holds only because the address decode sends each processor to exactly one module per cycle. The read-return checks assume each memory presents its data on the edge after it was strobed. The bench keeps to this by modelling every module as a RAM that registers its read on that edge. It changes requests and addresses only on the falling edge, so the combinational acknowledge is settled before it is sampled. The sweep covers every mix of idle and module choice over four processors and four modules, and the priority and hold behaviour is computed arithmetically for each mix.

// File: rtl/xbarPkg.sv
package xbarPkg;
  // Owner index width; rows beyond 2**OWNER_W are not representable.
  localparam int OWNER_W = 4;

  // Strobes passed from the arbitration control to the datapath, one per column.
  typedef struct packed {
    logic               hit;    // column claimed this cycle
    logic               we;     // write-enable of the owning row
    logic [OWNER_W-1:0] owner;  // row index that won the column
  } colStrobe_t;
endpackage

// File: rtl/xbarCrosspoint.sv
module xbarCrosspoint #(
  parameter int SEL_W = 2,
  parameter int COL   = 0
) (
  input  logic             req,
  input  logic [SEL_W-1:0] sel,
  input  logic             busyIn,
  output logic             hit,
  output logic             grant,
  output logic             busyOut
);
  // Decode: does this row aim at this column?
  assign hit     = req && (sel == SEL_W'(COL));
  // Grant only if no earlier row has already taken the column.
  assign grant   = hit && !busyIn;
  assign busyOut = busyIn || hit;
endmodule

// File: rtl/xbarCtrl.sv
module xbarCtrl
  import xbarPkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_MEM = 4,
  parameter int SEL_W   = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_CPU-1:0]        cpuReq,
  input  logic [NUM_CPU-1:0]        cpuWe,
  input  logic [NUM_CPU*SEL_W-1:0]  cpuSel,
  output logic [NUM_CPU-1:0]        cpuAck,
  output colStrobe_t [NUM_MEM-1:0]  colStb
);
  logic [NUM_MEM-1:0][NUM_CPU:0]   busy;
  logic [NUM_MEM-1:0][NUM_CPU-1:0] hit;
  logic [NUM_MEM-1:0][NUM_CPU-1:0] grant;

  for (genvar j = 0; j < NUM_MEM; j++) begin : gCol
    assign busy[j][0] = 1'b0;
    for (genvar i = 0; i < NUM_CPU; i++) begin : gRow
      xbarCrosspoint #(.SEL_W(SEL_W), .COL(j)) uXp (
        .req    (cpuReq[i]),
        .sel    (cpuSel[i*SEL_W +: SEL_W]),
        .busyIn (busy[j][i]),
        .hit    (hit[j][i]),
        .grant  (grant[j][i]),
        .busyOut(busy[j][i+1])
      );

      // R4: a granted row has no lower-indexed row hitting the same column
      a_r4_lowest_wins: assert property (@(posedge clk) disable iff (!rstN)
        grant[j][i] |-> ((hit[j] & NUM_CPU'((1 << i) - 1)) == '0));
    end

    // R4: at most one grant per column
    a_r4_single_grant: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(grant[j]));
    // R2: any hit on the column yields a grant on it
    a_r2_hit_gets_grant: assert property (@(posedge clk) disable iff (!rstN)
      (|hit[j]) |-> (|grant[j]));
  end

  // Acknowledge: OR of the row's grants across all columns.
  always_comb begin
    cpuAck = '0;
    for (int j = 0; j < NUM_MEM; j++) begin
      for (int i = 0; i < NUM_CPU; i++) begin
        if (grant[j][i]) cpuAck[i] = 1'b1;
      end
    end
  end

  // Column strobes toward the datapath.
  always_comb begin
    for (int j = 0; j < NUM_MEM; j++) begin
      colStb[j].hit   = busy[j][NUM_CPU];
      colStb[j].we    = 1'b0;
      colStb[j].owner = '0;
      for (int i = 0; i < NUM_CPU; i++) begin
        if (grant[j][i]) begin
          colStb[j].we    = cpuWe[i];
          colStb[j].owner = OWNER_W'(i);
        end
      end
    end
  end

  for (genvar i = 0; i < NUM_CPU; i++) begin : gAckChk
    // R3: no acknowledge without a request
    a_r3_ack_needs_req: assert property (@(posedge clk) disable iff (!rstN)
      cpuAck[i] |-> cpuReq[i]);
  end
endmodule

// File: rtl/xbarData.sv
module xbarData
  import xbarPkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_MEM = 4,
  parameter int WORD_W  = 4,
  parameter int DATA_W  = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  colStrobe_t [NUM_MEM-1:0]    colStb,
  input  logic [NUM_CPU*WORD_W-1:0]   cpuWord,
  input  logic [NUM_CPU*DATA_W-1:0]   cpuWdata,
  input  logic [NUM_MEM*DATA_W-1:0]   memRdata,
  output logic [NUM_MEM-1:0]          memSel,
  output logic [NUM_MEM-1:0]          memWe,
  output logic [NUM_MEM*WORD_W-1:0]   memAddr,
  output logic [NUM_MEM*DATA_W-1:0]   memWdata,
  output logic [NUM_CPU*DATA_W-1:0]   cpuRdata
);
  logic [NUM_MEM-1:0]              rdValid;
  logic [NUM_MEM-1:0][OWNER_W-1:0] rdOwner;
  logic [NUM_CPU-1:0][NUM_MEM-1:0] retMat;

  // Forward path: route the owning row onto each column.
  always_comb begin
    memAddr  = '0;
    memWdata = '0;
    for (int j = 0; j < NUM_MEM; j++) begin
      memSel[j] = colStb[j].hit;
      memWe[j]  = colStb[j].hit && colStb[j].we;
      for (int i = 0; i < NUM_CPU; i++) begin
        if (colStb[j].hit && (colStb[j].owner == OWNER_W'(i))) begin
          memAddr[j*WORD_W +: WORD_W]  = cpuWord[i*WORD_W +: WORD_W];
          memWdata[j*DATA_W +: DATA_W] = cpuWdata[i*DATA_W +: DATA_W];
        end
      end
    end
  end

  // Remember which row owns each column's read for the return cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= '0;
      rdOwner <= '0;
    end else begin
      for (int j = 0; j < NUM_MEM; j++) begin
        rdValid[j] <= colStb[j].hit && !colStb[j].we;
        rdOwner[j] <= colStb[j].owner;
      end
    end
  end

  // Return path: steer each column's read data to its recorded owner only.
  always_comb begin
    cpuRdata = '0;
    for (int i = 0; i < NUM_CPU; i++) begin
      for (int j = 0; j < NUM_MEM; j++) begin
        retMat[i][j] = rdValid[j] && (rdOwner[j] == OWNER_W'(i));
        if (retMat[i][j]) cpuRdata[i*DATA_W +: DATA_W] |= memRdata[j*DATA_W +: DATA_W];
      end
    end
  end

  for (genvar i = 0; i < NUM_CPU; i++) begin : gRetChk
    // R7: a processor gets read data from at most one module per cycle
    a_r7_single_return: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(retMat[i]));
  end

  for (genvar j = 0; j < NUM_MEM; j++) begin : gColChk
    // R8: a write strobe leaves no read pending on that column next cycle
    a_r8_write_no_return: assert property (@(posedge clk) disable iff (!rstN)
      memWe[j] |=> !rdValid[j]);
  end
endmodule

// File: rtl/xbarSwitch.sv
module xbarSwitch
  import xbarPkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_MEM = 4,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 8,
  localparam int SEL_W  = $clog2(NUM_MEM),
  localparam int WORD_W = ADDR_W - SEL_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_CPU-1:0]         cpuReq,
  input  logic [NUM_CPU-1:0]         cpuWe,
  input  logic [NUM_CPU*ADDR_W-1:0]  cpuAddr,
  input  logic [NUM_CPU*DATA_W-1:0]  cpuWdata,
  output logic [NUM_CPU-1:0]         cpuAck,
  output logic [NUM_CPU*DATA_W-1:0]  cpuRdata,
  output logic [NUM_MEM-1:0]         memSel,
  output logic [NUM_MEM-1:0]         memWe,
  output logic [NUM_MEM*WORD_W-1:0]  memAddr,
  output logic [NUM_MEM*DATA_W-1:0]  memWdata,
  input  logic [NUM_MEM*DATA_W-1:0]  memRdata
);
  logic [NUM_CPU*SEL_W-1:0]  cpuSel;
  logic [NUM_CPU*WORD_W-1:0] cpuWord;
  colStrobe_t [NUM_MEM-1:0]  colStb;

  // R1: split each address into module select (top bits) and word (low bits).
  always_comb begin
    for (int i = 0; i < NUM_CPU; i++) begin
      cpuSel[i*SEL_W +: SEL_W]   = cpuAddr[i*ADDR_W + WORD_W +: SEL_W];
      cpuWord[i*WORD_W +: WORD_W] = cpuAddr[i*ADDR_W +: WORD_W];
    end
  end

  xbarCtrl #(.NUM_CPU(NUM_CPU), .NUM_MEM(NUM_MEM), .SEL_W(SEL_W)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .cpuReq(cpuReq),
    .cpuWe (cpuWe),
    .cpuSel(cpuSel),
    .cpuAck(cpuAck),
    .colStb(colStb)
  );

  xbarData #(.NUM_CPU(NUM_CPU), .NUM_MEM(NUM_MEM), .WORD_W(WORD_W), .DATA_W(DATA_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .colStb  (colStb),
    .cpuWord (cpuWord),
    .cpuWdata(cpuWdata),
    .memRdata(memRdata),
    .memSel  (memSel),
    .memWe   (memWe),
    .memAddr (memAddr),
    .memWdata(memWdata),
    .cpuRdata(cpuRdata)
  );

  // R2/R5: every acknowledged processor occupies exactly one strobed module
  a_r5_sel_matches_ack: assert property (@(posedge clk) disable iff (!rstN)
    $countones(memSel) == $countones(cpuAck));
endmodule

// File: tb/xbarSwitch_test.sv
module xbarSwitch_test;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4, NM = 4, AW = 6, DW = 8, WW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NC-1:0]    cpuReq = '0, cpuWe = '0, cpuAck;
  logic [NC*AW-1:0] cpuAddr = '0;
  logic [NC*DW-1:0] cpuWdata = '0, cpuRdata;
  logic [NM-1:0]    memSel, memWe;
  logic [NM*WW-1:0] memAddr;
  logic [NM*DW-1:0] memWdata, memRdata = '0;
  logic [DW-1:0]    ram [NM][1<<WW];
  logic [NC*DW-1:0] expRd = '0;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbarSwitch #(.NUM_CPU(NC), .NUM_MEM(NM), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuAck(cpuAck), .cpuRdata(cpuRdata), .memSel(memSel),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata));

  // Registered RAM model, one per module.
  always @(posedge clk) begin
    for (int j = 0; j < NM; j++) begin
      if (memSel[j]) begin
        if (memWe[j]) ram[j][memAddr[j*WW +: WW]] <= memWdata[j*DW +: DW];
        else memRdata[j*DW +: DW] <= ram[j][memAddr[j*WW +: WW]];
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input int cpu, input bit req, input bit we, input int col,
                       input int word, input logic [DW-1:0] wd);
    cpuReq[cpu] = req;
    cpuWe[cpu]  = we;
    cpuAddr[cpu*AW +: AW] = {col[1:0], word[3:0]};
    cpuWdata[cpu*DW +: DW] = wd;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < NM; j++)
      for (int k = 0; k < (1<<WW); k++) ram[j][k] = DW'(j*37 + k*5 + 1);

    // Reset state (R9)
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset rdata", cpuRdata, '0);
    check("R3 reset ack", cpuAck, '0);
    check("R2 reset memSel", memSel, '0);
    rstN = 1'b1;

    // Exhaustive sweep: each processor idle or aiming at one of the modules.
    for (int p = 0; p < 625; p++) begin
      int rem;
      int colOf [NC];
      int wordOf [NC];
      logic [NM-1:0] taken;
      logic [NC-1:0] expAck;
      logic [NM*WW-1:0] expAddr;
      logic [NM*DW-1:0] expWd;
      @(negedge clk);
      check("R7 read return", cpuRdata, expRd);
      rem = p;
      for (int i = 0; i < NC; i++) begin
        int d;
        d = rem % 5;
        rem = rem / 5;
        colOf[i]  = (d == 0) ? (i % NM) : d - 1;
        wordOf[i] = (p + 3*i) % 16;
        drive(i, d != 0, 1'b0, colOf[i], wordOf[i], DW'(p + 7*i));
      end
      taken = '0; expAck = '0; expAddr = '0; expWd = '0; expRd = '0;
      for (int i = 0; i < NC; i++) begin
        if (cpuReq[i] && !taken[colOf[i]]) begin
          taken[colOf[i]] = 1'b1;
          expAck[i] = 1'b1;
          expAddr[colOf[i]*WW +: WW] = WW'(wordOf[i]);
          expWd[colOf[i]*DW +: DW] = DW'(p + 7*i);
          expRd[i*DW +: DW] = ram[colOf[i]][wordOf[i]];
        end
      end
      #1;
      check("R3 R4 R5 ack same cycle, lowest index", cpuAck, expAck);
      check("R2 memSel", memSel, taken);
      check("R2 memWe read", memWe, '0);
      check("R1 memAddr word bits", memAddr, expAddr);
      check("R2 memWdata winner", memWdata, expWd);
    end

    // Write conflict then hold (R8, R6)
    @(negedge clk);
    check("R7 read return", cpuRdata, expRd);
    cpuReq = '0;
    drive(0, 1, 1, 2, 5, 8'hC3);
    drive(1, 1, 1, 2, 6, 8'h11);
    #1;
    check("R4 write conflict ack", cpuAck, 4'b0001);
    check("R2 memWe winner", memWe, 4'b0100);
    check("R2 memWdata write", memWdata[2*DW +: DW], 8'hC3);
    @(negedge clk);
    check("R8 no rdata after write", cpuRdata, '0);
    cpuReq[0] = 1'b0;
    #1;
    check("R6 held loser acked", cpuAck, 4'b0010);
    check("R1 held loser address", memAddr[2*WW +: WW], 4'd6);
    @(negedge clk);
    check("R8 no rdata after write", cpuRdata, '0);
    cpuReq = '0;
    drive(2, 1, 0, 2, 5, 8'h00);
    drive(3, 1, 0, 2, 6, 8'h00);
    #1;
    check("R4 read conflict ack", cpuAck, 4'b0100);
    @(negedge clk);
    check("R8 written data read back", cpuRdata, {8'h00, 8'hC3, 8'h00, 8'h00});
    cpuReq[2] = 1'b0;
    #1;
    check("R6 second loser acked", cpuAck, 4'b1000);
    @(negedge clk);
    check("R8 second write read back", cpuRdata, {8'h11, 8'h00, 8'h00, 8'h00});
    cpuReq = '0;
    #1;
    check("R3 idle ack", cpuAck, '0);
    @(negedge clk);
    check("R7 idle rdata zero", cpuRdata, '0);

    // Reset during an acknowledged read (R9)
    drive(0, 1, 0, 0, 3, 8'h00);
    #1;
    check("R3 ack before reset", cpuAck, 4'b0001);
    rstN = 1'b0;
    @(negedge clk);
    check("R9 rdata zero after reset edge", cpuRdata, '0);
    cpuReq = '0;
    rstN = 1'b1;
    @(negedge clk);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule